// File: doc/BRIEF.md
# Piezo Tone Pair Generator

This block produces two complementary square waves for a piezo buzzer that sits across two output pins. It runs at one of two pitches, a high one (nominally 4 kHz) and a low one (nominally 2 kHz). Both pitches come from a clock-enable pulse train at a nominal 32.768 kHz rate, the same base that feeds the chip's time base. A command decoder upstream sends single-cycle strobes that start the tone, stop it, and pick the pitch. A system-enable level can silence the buzzer at any time.

While the tone is silent, both pins sit low, so the piezo carries no DC bias. A pitch change is held back until the current output period ends. As a result, no shortened pulse ever reaches the buzzer. Each start of the tone, including a restart after the system enable comes back, begins a fresh period with the first pin high.

Top module: `buzz_tone_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it, both pins are low. Out of reset the tone is stopped and the low pitch is selected.
- R2: One clock after a start strobe is sampled with the system enabled, `bz_p` is 1 and `bz_n` is 0.
- R3: While the tone runs, `bz_n` is always the inverse of `bz_p`.
- R4: At the high pitch, each output level lasts exactly 4 base-enable pulses, which is a period of 8 pulses.
- R5: At the low pitch, each output level lasts exactly 8 base-enable pulses, which is a period of 16 pulses.
- R6: A pitch strobe received while the tone runs takes effect only when the current period wraps. The period in progress finishes with its old level lengths.
- R7: One clock after a stop strobe, or after the system enable is sampled low, both pins are low. They stay low until the tone runs again.
- R8: If the stop strobe and the start strobe arrive in the same cycle, stop wins. If both pitch strobes arrive in the same cycle, the low pitch wins.
- R9: A start strobe while the tone already runs does not change the phase.
- R10: When the system enable returns high with the tone still started, a fresh period begins at the pending pitch, with `bz_p` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_en | input | 1 | Base-rate enable pulse, one cycle wide |
| sys_en | input | 1 | System enable level; low silences the pins |
| cmd_tone_on | input | 1 | Strobe: start the tone |
| cmd_tone_off | input | 1 | Strobe: stop the tone |
| cmd_sel_hi | input | 1 | Strobe: select the high pitch (base / 8) |
| cmd_sel_lo | input | 1 | Strobe: select the low pitch (base / 16) |
| bz_p | output | 1 | Buzzer drive, true phase |
| bz_n | output | 1 | Buzzer drive, inverted phase |

## Verification
The directed patterns hold the base enable high on every cycle, so that level lengths at each pitch can be counted exactly. A pitch strobe is placed mid-period, which shows whether the switch is deferred or applied at once. Colliding strobes and a repeated start test the priority rules and whether the phase is kept. Toggling the system enable separates a true restart from a resumed phase. A long randomized stretch uses sparse base-enable pulses and rare strobes. It catches counters that advance on the clock instead of on the enable pulse.

// File: rtl/buzz_tone_pkg.sv
package buzz_tone_pkg;
  typedef enum logic {
    FREQ_LO = 1'b0,
    FREQ_HI = 1'b1
  } freq_e;
endpackage

// File: rtl/tone_cmd_regs.sv
module tone_cmd_regs
  import buzz_tone_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sys_en,
  input  logic  cmd_tone_on,
  input  logic  cmd_tone_off,
  input  logic  cmd_sel_hi,
  input  logic  cmd_sel_lo,
  output logic  run_nxt,
  output freq_e pend_nxt
);
  logic  on_q;
  freq_e pend_q;
  logic  on_nxt;

  // R8: stop beats start, low pitch beats high pitch
  always_comb begin
    on_nxt = on_q;
    if (cmd_tone_off)     on_nxt = 1'b0;
    else if (cmd_tone_on) on_nxt = 1'b1;

    pend_nxt = pend_q;
    if (cmd_sel_lo)      pend_nxt = FREQ_LO;
    else if (cmd_sel_hi) pend_nxt = FREQ_HI;

    run_nxt = on_nxt && sys_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= 1'b0;
      pend_q <= FREQ_LO;
    end else begin
      on_q   <= on_nxt;
      pend_q <= pend_nxt;
    end
  end

  a_r8_stop_wins: assert property (@(posedge clk) disable iff (rst)
    cmd_tone_off |=> !on_q);
endmodule

// File: rtl/tone_divider.sv
module tone_divider
  import buzz_tone_pkg::*;
#(
  parameter int DIV_HI = 8,
  parameter int DIV_LO = 16,
  localparam int CNT_W = $clog2(DIV_LO)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  base_en,
  input  logic  run_nxt,
  input  freq_e pend_nxt,
  output logic  level_nxt
);
  logic             run_q;
  freq_e            act_q, act_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  function automatic logic [CNT_W-1:0] last_of(freq_e f);
    return (f == FREQ_HI) ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);
  endfunction

  function automatic logic [CNT_W-1:0] half_of(freq_e f);
    return (f == FREQ_HI) ? CNT_W'(DIV_HI / 2) : CNT_W'(DIV_LO / 2);
  endfunction

  always_comb begin
    act_nxt = act_q;
    cnt_nxt = cnt_q;
    if (!run_nxt || !run_q) begin
      cnt_nxt = '0;
      act_nxt = pend_nxt;
    end else if (base_en) begin
      if (cnt_q == last_of(act_q)) begin
        cnt_nxt = '0;
        act_nxt = pend_nxt;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
    level_nxt = run_nxt && (cnt_nxt < half_of(act_nxt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      act_q <= FREQ_LO;
      cnt_q <= '0;
    end else begin
      run_q <= run_nxt;
      act_q <= act_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q <= last_of(act_q)));

  a_r6_switch_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && (act_q != $past(act_q))) |-> (cnt_q == '0));

  a_r5_idle_clock: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && !$past(base_en)) |-> $stable(cnt_q));
endmodule

// File: rtl/tone_out_stage.sv
module tone_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic run_nxt,
  input  logic level_nxt,
  output logic bz_p,
  output logic bz_n
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      bz_p  <= 1'b0;
      bz_n  <= 1'b0;
    end else begin
      run_q <= run_nxt;
      bz_p  <= level_nxt;
      bz_n  <= run_nxt && !level_nxt;
    end
  end

  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (!bz_p && !bz_n));

  a_r3_complement: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (bz_p != bz_n));

  a_r7_silent_low: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (!bz_p && !bz_n));

  a_r2_start_high: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> (bz_p && !bz_n));
endmodule

// File: rtl/buzz_tone_gen.sv
module buzz_tone_gen
  import buzz_tone_pkg::*;
#(
  parameter int TONE_HI_DIV = 8,
  parameter int TONE_LO_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic base_en,
  input  logic sys_en,
  input  logic cmd_tone_on,
  input  logic cmd_tone_off,
  input  logic cmd_sel_hi,
  input  logic cmd_sel_lo,
  output logic bz_p,
  output logic bz_n
);
  logic  run_nxt;
  freq_e pend_nxt;
  logic  level_nxt;

  tone_cmd_regs u_cmd (
    .clk          (clk),
    .rst          (rst),
    .sys_en       (sys_en),
    .cmd_tone_on  (cmd_tone_on),
    .cmd_tone_off (cmd_tone_off),
    .cmd_sel_hi   (cmd_sel_hi),
    .cmd_sel_lo   (cmd_sel_lo),
    .run_nxt      (run_nxt),
    .pend_nxt     (pend_nxt)
  );

  tone_divider #(
    .DIV_HI (TONE_HI_DIV),
    .DIV_LO (TONE_LO_DIV)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .base_en   (base_en),
    .run_nxt   (run_nxt),
    .pend_nxt  (pend_nxt),
    .level_nxt (level_nxt)
  );

  tone_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .run_nxt   (run_nxt),
    .level_nxt (level_nxt),
    .bz_p      (bz_p),
    .bz_n      (bz_n)
  );

  a_r7_sys_off: assert property (@(posedge clk) disable iff (rst)
    !sys_en |=> (!bz_p && !bz_n));

  a_r7_stop: assert property (@(posedge clk) disable iff (rst)
    cmd_tone_off |=> (!bz_p && !bz_n));
endmodule

// File: tb/buzz_tone_gen_test.sv
module buzz_tone_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic base_en = 1'b0, sys_en = 1'b0;
  logic c_on = 1'b0, c_off = 1'b0, c_hi = 1'b0, c_lo = 1'b0;
  logic bz_p, bz_n;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model of the requirements
  bit m_on, m_pend, m_act, m_prun;
  int m_pos;

  always #(CLK_PERIOD/2) clk = ~clk;

  buzz_tone_gen uut (
    .clk          (clk),
    .rst          (rst),
    .base_en      (base_en),
    .sys_en       (sys_en),
    .cmd_tone_on  (c_on),
    .cmd_tone_off (c_off),
    .cmd_sel_hi   (c_hi),
    .cmd_sel_lo   (c_lo),
    .bz_p         (bz_p),
    .bz_n         (bz_n)
  );

  // period in base pulses: 1 = high pitch (R4), 0 = low pitch (R5)
  function automatic int period_of(bit f);
    return f ? 8 : 16;
  endfunction

  function automatic void model_step();
    bit run;
    if (rst) begin
      m_on = 0; m_pend = 0; m_act = 0; m_pos = 0; m_prun = 0;
      return;
    end
    if (c_lo)      m_pend = 0;       // R8
    else if (c_hi) m_pend = 1;
    if (c_off)     m_on = 0;         // R8
    else if (c_on) m_on = 1;
    run = m_on && sys_en;
    if (!run || !m_prun) begin       // R2, R7, R10
      m_pos = 0; m_act = m_pend;
    end else if (base_en) begin
      if (m_pos == period_of(m_act) - 1) begin  // R6
        m_pos = 0; m_act = m_pend;
      end else m_pos++;
    end
    m_prun = run;
  endfunction

  task automatic tick(string tag, bit be, bit se, bit on, bit off, bit hi, bit lo);
    bit ep, en, run;
    base_en = be; sys_en = se; c_on = on; c_off = off; c_hi = hi; c_lo = lo;
    @(posedge clk);
    model_step();
    @(negedge clk);
    run = m_prun;
    ep = run && (m_pos < period_of(m_act) / 2);
    en = run && !ep;
    n_tests++;
    if (bz_p !== ep || bz_n !== en) begin
      n_fail++;
      $display("FAIL %s: bz_p/bz_n = %b%b, expected %b%b", tag, bz_p, bz_n, ep, en);
    end
  endtask

  task automatic idle(string tag, int n, bit se);
    for (int i = 0; i < n; i++) tick(tag, 1'b1, se, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    // R1: reset state
    rst = 1'b1;
    repeat (3) tick("R1", 1, 1, 0, 0, 0, 0);
    rst = 1'b0;
    idle("R1", 3, 1'b1);
    // R1/R5: default low pitch; R2 start high
    tick("R2", 1, 1, 1, 0, 0, 0);
    idle("R5", 40, 1'b1);
    // R6: high pitch selected mid-period, applied at wrap
    idle("R6", 3, 1'b1);
    tick("R6", 1, 1, 0, 0, 1, 0);
    idle("R6", 20, 1'b1);
    // R4: high pitch levels
    idle("R4", 24, 1'b1);
    // R9: repeated start keeps phase
    tick("R9", 1, 1, 1, 0, 0, 0);
    idle("R9", 10, 1'b1);
    // R8: both pitch strobes -> low pitch
    tick("R8", 1, 1, 0, 0, 1, 1);
    idle("R8", 40, 1'b1);
    // R7: system disable; R10: restart on re-enable
    idle("R7", 5, 1'b0);
    idle("R10", 20, 1'b1);
    // R8: stop and start together -> stopped
    tick("R8", 1, 1, 1, 1, 0, 0);
    idle("R8", 6, 1'b1);
    // R7: stop strobe
    tick("R2", 1, 1, 1, 0, 1, 0);
    idle("R4", 6, 1'b1);
    tick("R7", 1, 1, 0, 1, 0, 0);
    idle("R7", 6, 1'b1);
    // random mix, sparse base pulses and rare strobes
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      tick("R3", ($urandom_range(0, 3) == 0), ($urandom_range(0, 49) != 0),
           (r < 3), (r == 3), (r == 4 || r == 6), (r == 5 || r == 6));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule